// File: doc/BRIEF.md
# Encoder Pulse-Rate Estimator

This block turns the decoded pulse stream of an incremental encoder into speed and speed-change figures at fixed, hardware-timed instants. A decoder upstream supplies a one-cycle count strobe and a direction bit. The block keeps a signed running total of those strobes over a window of a programmable number of clock cycles. When the window closes, the total becomes the velocity estimate. The difference between this total and the one from the window before becomes the acceleration estimate.

Both estimates are proportional to the physical quantity, because every window is equally long. A host or control loop applies the scaling to physical units and the division by the window time. Results appear on a fixed cadence, with a one-cycle valid pulse. A separate flag tells the consumer whether the acceleration figure is backed by two real windows.

Top module: `enc_rate_est`

## Requirements
- R1: While `rst_n` is low and after it is released, `vel_q` and `acc_q` read 0, and `est_vld` and `acc_vld` read 0 until the first window closes.
- R2: A window lasts exactly `win_len`+1 clock cycles. The internal cycle timer restarts at 0 right after the closing cycle, so no cycle is lost between windows. With `win_len` = 0, every cycle closes a window. If `win_len` is lowered below the running timer value, the current window closes on the next cycle.
- R3: Each strobe counts +1 when `cnt_dir` = 1 and −1 when `cnt_dir` = 0. The net signed count of a window appears on `vel_q` in the cycle after the window closes, together with `est_vld`.
- R4: `est_vld` is high for exactly one cycle per closed window. It is therefore high on every cycle only when `win_len` = 0.
- R5: A strobe sampled in the closing cycle of a window is credited to the following window, not to the closing one.
- R6: `acc_q` equals the new `vel_q` minus the previous `vel_q`, as a signed value one bit wider than `vel_q`. After the first window following reset, `acc_vld` = 0 and `acc_q` = 0. From the second window on, `acc_vld` = 1.
- R7: The running count saturates at +(2^(CNT_W−1)−1) and −2^(CNT_W−1) instead of wrapping. The next window starts again from 0.
- R8: `vel_q`, `acc_q` and `acc_vld` hold their values between window closings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_stb | input | 1 | One-cycle pulse per decoded encoder edge |
| cnt_dir | input | 1 | Direction of the strobe: 1 counts up, 0 counts down |
| win_len | input | WIN_W | Terminal timer value; window length is win_len+1 cycles |
| vel_q | output | CNT_W | Signed net pulse count of the last closed window |
| acc_q | output | CNT_W+1 | Signed difference between the last two window counts |
| est_vld | output | 1 | One-cycle pulse when new estimates are presented |
| acc_vld | output | 1 | acc_q is based on two real windows |

## Verification
The hardest situations to reach are saturation and a strobe that lands exactly on the closing cycle. Saturation needs more same-direction strobes in one window than the count can hold. The bench narrows the count to 8 bits and stretches the window to 200 cycles, so a strobe on every cycle runs past both limits. For the closing-cycle case, the bench locks onto the valid pulse and counts cycles from there. This places a strobe precisely on the cycle that ends the next window, and the bench then checks that the strobe shows up in the window after it.

// File: rtl/enc_rate_pkg.sv
package enc_rate_pkg;

  // One decoded encoder event, or none, in a given cycle.
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  // Collapses the decoder's strobe/direction pair into a single event.
  function automatic step_e step_of(input logic stb, input logic dir);
    if (!stb)     return STEP_NONE;
    else if (dir) return STEP_UP;
    else          return STEP_DN;
  endfunction

endpackage

// File: rtl/enc_win_timer.sv
module enc_win_timer #(
  parameter int WIN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_len,
  output logic             bnd,
  output logic [WIN_W-1:0] tmr_q
);

  localparam logic [WIN_W-1:0] TMR_ONE = {{(WIN_W-1){1'b0}}, 1'b1};

  // ">=" rather than "==" so that a terminal value lowered mid-window
  // cannot strand the timer above it for a full wrap of the counter.
  assign bnd = (tmr_q >= win_len);

  always_ff @(posedge clk) begin
    if (!rst_n)   tmr_q <= '0;
    else if (bnd) tmr_q <= '0;
    else          tmr_q <= tmr_q + TMR_ONE;
  end

endmodule

// File: rtl/enc_pulse_acc.sv
module enc_pulse_acc
  import enc_rate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bnd,
  input  step_e                   step,
  output logic signed [CNT_W-1:0] cnt_q
);

  localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic signed [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // A pegged count still tells the loop "at least this fast", whereas a
  // wrapped one would flip the sign of the speed.
  function automatic logic signed [CNT_W-1:0] sat_step(
    input logic signed [CNT_W-1:0] base,
    input step_e                   s
  );
    case (s)
      STEP_UP: return (base == CNT_MAX) ? base : base + CNT_ONE;
      STEP_DN: return (base == CNT_MIN) ? base : base - CNT_ONE;
      default: return base;
    endcase
  endfunction

  logic signed [CNT_W-1:0] base;
  logic signed [CNT_W-1:0] cnt_d;

  // On the closing cycle the old total leaves for the estimate register,
  // and this cycle's event seeds the next window.
  assign base  = bnd ? '0 : cnt_q;
  assign cnt_d = sat_step(base, step);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (!bnd && step == STEP_UP && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R7
  AST_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (!bnd && step == STEP_DN && cnt_q == CNT_MIN) |=> (cnt_q == CNT_MIN)); // R7
  AST_BND_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && step != STEP_NONE) |=> (cnt_q != '0)); // R5

endmodule

// File: rtl/enc_est_reg.sv
module enc_est_reg #(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bnd,
  input  logic signed [CNT_W-1:0] win_cnt,
  output logic signed [CNT_W-1:0] vel_q,
  output logic signed [CNT_W:0]   acc_q,
  output logic                    est_vld,
  output logic                    acc_vld
);

  // One extra bit: two opposite full-scale windows differ by almost 2x range.
  function automatic logic signed [CNT_W:0] cnt_diff(
    input logic signed [CNT_W-1:0] now_c,
    input logic signed [CNT_W-1:0] old_c
  );
    logic signed [CNT_W:0] a;
    logic signed [CNT_W:0] b;
    a = {now_c[CNT_W-1], now_c};
    b = {old_c[CNT_W-1], old_c};
    return a - b;
  endfunction

  logic have_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vel_q     <= '0;
      acc_q     <= '0;
      est_vld   <= 1'b0;
      acc_vld   <= 1'b0;
      have_prev <= 1'b0;
    end else begin
      est_vld <= bnd;
      if (bnd) begin
        vel_q     <= win_cnt;
        // After reset vel_q holds no real window, so differencing against it
        // would report a spurious jump.
        acc_q     <= have_prev ? cnt_diff(win_cnt, vel_q) : '0;
        acc_vld   <= have_prev;
        have_prev <= 1'b1;
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> !est_vld); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> ($stable(vel_q) && $stable(acc_q) && $stable(acc_vld))); // R8
  AST_ACC_WITH_EST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_vld) |-> est_vld); // R6
  AST_ACC_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (est_vld && !acc_vld) |-> (acc_q == '0)); // R6

endmodule

// File: rtl/enc_rate_est.sv
module enc_rate_est
  import enc_rate_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WIN_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cnt_stb,
  input  logic                    cnt_dir,
  input  logic [WIN_W-1:0]        win_len,
  output logic signed [CNT_W-1:0] vel_q,
  output logic signed [CNT_W:0]   acc_q,
  output logic                    est_vld,
  output logic                    acc_vld
);

  // Named internal events, visible to the assertions below.
  logic                    win_bnd;
  logic [WIN_W-1:0]        win_tmr;
  step_e                   win_step;
  logic signed [CNT_W-1:0] run_cnt;

  assign win_step = step_of(cnt_stb, cnt_dir);

  enc_win_timer #(.WIN_W(WIN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_len (win_len),
    .bnd     (win_bnd),
    .tmr_q   (win_tmr)
  );

  enc_pulse_acc #(.CNT_W(CNT_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .bnd   (win_bnd),
    .step  (win_step),
    .cnt_q (run_cnt)
  );

  enc_est_reg #(.CNT_W(CNT_W)) u_est (
    .clk     (clk),
    .rst_n   (rst_n),
    .bnd     (win_bnd),
    .win_cnt (run_cnt),
    .vel_q   (vel_q),
    .acc_q   (acc_q),
    .est_vld (est_vld),
    .acc_vld (acc_vld)
  );

  AST_RESTART_ON_PUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
    est_vld |-> (win_tmr == '0)); // R2
  AST_PUBLISH_MATCHES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    win_bnd |=> (vel_q == $past(run_cnt))); // R3

endmodule

// File: tb/enc_rate_est_bench.sv
module enc_rate_est_bench;

  localparam int CW = 8;
  localparam int WW = 16;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 cnt_stb;
  logic                 cnt_dir;
  logic [WW-1:0]        win_len;
  logic signed [CW-1:0] vel_q;
  logic signed [CW:0]   acc_q;
  logic                 est_vld;
  logic                 acc_vld;

  int n_chk  = 0;
  int n_fail = 0;
  int cur_len;
  int carry;     // contribution already credited to the running window
  int prev_vel;
  bit have_prev;
  bit done = 1'b0;

  always #10 clk = ~clk;

  enc_rate_est #(.CNT_W(CW), .WIN_W(WW)) u_enc_rate_est (
    .clk(clk), .rst_n(rst_n), .cnt_stb(cnt_stb), .cnt_dir(cnt_dir),
    .win_len(win_len), .vel_q(vel_q), .acc_q(acc_q),
    .est_vld(est_vld), .acc_vld(acc_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat8(input int v);
    if (v > 127)  return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic sync_pulse();
    do @(negedge clk); while (!est_vld);
  endtask

  // Starts right after an estimate pulse. Drives the remaining cur_len
  // slots of the running window (ups first, then downs), then the closing
  // slot with nxt (-1, 0, +1), which belongs to the following window.
  task automatic run_win(input int up, input int dn, input int nxt, input string tag);
    int exp_v = carry;
    int exp_a;
    int held = vel_q;
    for (int s = 0; s < cur_len; s++) begin
      cnt_stb = (s < up + dn);
      cnt_dir = (s < up);
      if (s < up) exp_v = sat8(exp_v + 1);
      else if (s < up + dn) exp_v = sat8(exp_v - 1);
      @(negedge clk);
      if (s == 0) begin
        chk(est_vld == 1'b0, {"R4 pulse width ", tag}, est_vld, 0);
        chk(vel_q == held, {"R8 hold ", tag}, vel_q, held);
      end
    end
    cnt_stb = (nxt != 0);
    cnt_dir = (nxt > 0);
    @(negedge clk);
    cnt_stb = 1'b0;
    exp_a = have_prev ? exp_v - prev_vel : 0;
    chk(est_vld == 1'b1, {"R2 window close ", tag}, est_vld, 1);
    chk(vel_q == exp_v, {"R3 velocity ", tag}, vel_q, exp_v);
    chk(acc_q == exp_a, {"R6 acceleration ", tag}, acc_q, exp_a);
    chk(acc_vld == have_prev, {"R6 acc flag ", tag}, acc_vld, have_prev);
    prev_vel  = exp_v;
    have_prev = 1'b1;
    carry     = nxt;
  endtask

  task automatic set_len(input int n);
    int gap = 0;
    win_len = WW'(n);
    cur_len = n;
    sync_pulse();
    sync_pulse();
    do begin @(negedge clk); gap++; end while (!est_vld);
    chk(gap == n + 1, "R2 window period", gap, n + 1);
    chk(vel_q == 0, "R3 idle window", vel_q, 0);
    prev_vel = 0;
    carry    = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cnt_stb = 1'b0; cnt_dir = 1'b0; win_len = WW'(9);
    cur_len = 9;
    repeat (3) @(negedge clk);
    chk(vel_q == 0 && acc_q == 0, "R1 reset values", vel_q, 0);
    chk(est_vld == 0 && acc_vld == 0, "R1 reset flags", est_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(est_vld == 0, "R1 no pulse after release", est_vld, 0);
    sync_pulse();
    chk(acc_vld == 0 && acc_q == 0, "R6 first window flag", acc_vld, 0);
    chk(vel_q == 0, "R3 first window", vel_q, 0);
    have_prev = 1'b0; prev_vel = 0; carry = 0;
    have_prev = 1'b1;
  endtask

  task automatic t_basic();
    run_win(5, 2, 1, "mixed");
    run_win(0, 4, 0, "credit up");  // R5: carry +1 from closing cycle
    run_win(1, 0, -1, "carry down");
    run_win(2, 0, 0, "credit down"); // R5: carry -1
  endtask

  task automatic t_period();
    set_len(3);
    run_win(3, 0, 0, "short");
    set_len(0);
    run_win(0, 0, 1, "len0 a");
    run_win(0, 0, -1, "len0 b");
    run_win(0, 0, 0, "len0 c");
    chk(est_vld == 1'b1, "R4 continuous at len0", est_vld, 1);
  endtask

  task automatic t_sat();
    set_len(199);
    run_win(199, 0, 0, "sat high");  // R7
    run_win(0, 199, 0, "sat low");   // R7
    run_win(3, 0, 0, "after sat");   // R7 fresh start
  endtask

  task automatic t_rereset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(vel_q == 0 && acc_vld == 0, "R1 re-reset", vel_q, 0);
    rst_n = 1'b1;
    sync_pulse();
    chk(acc_vld == 0, "R6 flag after re-reset", acc_vld, 0);
    have_prev = 1'b1; prev_vel = 0; carry = 0;
    run_win(4, 0, 0, "post reset");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_period();
    t_sat();
    t_rereset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule